// File: doc/BRIEF.md
# DMA Bus Master Controller

This block is the single path by which two internal DMA requesters reach a host-bus interface unit. The first requester is a descriptor list processor. It fetches endpoint descriptors, transfer descriptors and the shared communication area. The second is a data buffer engine, which moves the payload that a transfer descriptor points to. The controller selects one requester as owner. It latches that owner's start byte address, byte count and direction, and presents them to the bus interface. It then raises a bus request.

The bus interface answers by raising a cycle-active signal, which stays high until the whole cycle is over. Inside that window it strobes a one-clock data-ready pulse for every dword moved. On a write, each strobe tells the owner that its current dword was consumed, and the owner presents the next dword on the following clock. On a read, each strobe marks the clock on which the owner must capture the dword on the read data bus. When the expected number of dwords has moved, the owner receives a one-clock done pulse.

The list processor has priority over the data engine. The data engine can only gain the bus while the list processor yields it, which the list processor does when descriptor-referenced data has to move.

Top module: `dma_busmaster_ctl`

## Requirements
- R1: While reset is held and after its release, `bif_req`, `lp_own`, `de_own`, `lp_done` and `de_done` are all low until a requester asks for the bus.
- R2: `bif_req` rises only on a clock at which `bif_active` was sampled low. It falls on the clock after `bif_active` is sampled low at the end of a granted cycle. While `bif_active` is high and no cycle is granted, no request is raised.
- R3: From the rise of `bif_req` until its fall, `bif_addr`, `bif_size` and `bif_write` hold the owner's start byte address, byte count and direction (1 = write), and do not change.
- R4: The dword count of a cycle is ceil((`bif_addr[1:0]` + `bif_size`) / 4). The owner's done output pulses for exactly one clock, on the clock after the data-ready strobe that completes that count. Any data-ready beyond the count produces no strobe to a requester.
- R5: On a write, each counted data-ready asserts the owner's `*_wnext` in the same clock, and `bif_wdata` carries the owner's `*_wdata`.
- R6: On a read, each counted data-ready asserts the owner's `*_rvalid` in the same clock, and `rd_data` equals `bif_rdata`.
- R7: When both requesters are pending, the data engine is allowed, and no one owns the bus, the list processor becomes owner (`lp_own` = 1).
- R8: `de_req` has no effect while `lp_yield` is low: `bif_req` and `de_own` stay low. Once `lp_yield` is high, the data engine is granted (`de_own` = 1).
- R9: At most one of `lp_own` and `de_own` is high. Strobes and done go only to the owner, and the other requester sees none.
- R10: A `bif_dready` pulse while `bif_active` is low produces no strobe and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req | input | 1 | List processor wants a bus cycle |
| lp_addr | input | AW | List processor start byte address |
| lp_size | input | SW | List processor byte count |
| lp_write | input | 1 | List processor direction, 1 = write |
| lp_wdata | input | DW | List processor write dword |
| lp_yield | input | 1 | List processor allows the data engine to take the bus |
| lp_own | output | 1 | List processor owns the current cycle |
| lp_wnext | output | 1 | List processor write dword consumed |
| lp_rvalid | output | 1 | List processor read dword valid on rd_data |
| lp_done | output | 1 | List processor cycle complete |
| de_req | input | 1 | Data engine wants a bus cycle |
| de_addr | input | AW | Data engine start byte address |
| de_size | input | SW | Data engine byte count |
| de_write | input | 1 | Data engine direction, 1 = write |
| de_wdata | input | DW | Data engine write dword |
| de_own | output | 1 | Data engine owns the current cycle |
| de_wnext | output | 1 | Data engine write dword consumed |
| de_rvalid | output | 1 | Data engine read dword valid on rd_data |
| de_done | output | 1 | Data engine cycle complete |
| rd_data | output | DW | Read dword returned to the owner |
| bif_req | output | 1 | Bus cycle request |
| bif_addr | output | AW | Start byte address of the cycle |
| bif_size | output | SW | Byte count of the cycle |
| bif_write | output | 1 | Cycle direction, 1 = write |
| bif_wdata | output | DW | Write dword to the bus interface |
| bif_active | input | 1 | Cycle in progress |
| bif_dready | input | 1 | One-clock pulse per dword moved |
| bif_rdata | input | DW | Read dword from the bus interface |

## Verification
A wrong beat counter appears at the owner's done output. The pulse arrives a clock early or late relative to the final data-ready, or it never comes. In the latter case `bif_req` still drops once cycle-active falls, so the fault is visible within one cycle length. A wrong latched owner shows up on the first strobe, as `*_wnext` or `*_rvalid` on the wrong requester. A wrong sequencer state shows up within one clock of the cycle-active edges, as a request that rises under an active window or lingers after it.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LP   = 2'd1,
    OWN_DE   = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bm_owner_arb.sv
module bm_owner_arb
  import bm_pkg::*;
(
  input  logic   can_start,
  input  logic   lp_req,
  input  logic   de_req,
  input  logic   lp_yield,
  output owner_e pick
);

  // list processor first; data engine only by its leave
  always_comb begin
    pick = OWN_NONE;
    if (can_start) begin
      if (lp_req)                  pick = OWN_LP;
      else if (de_req && lp_yield) pick = OWN_DE;
    end
  end

endmodule

// File: rtl/bm_xfer_seq.sv
module bm_xfer_seq
  import bm_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  owner_e        pick,
  input  logic [AW-1:0] sel_addr,
  input  logic [SW-1:0] sel_size,
  input  logic          sel_write,
  input  logic          bif_active,
  input  logic          bif_dready,
  output logic          bif_req,
  output logic [AW-1:0] bif_addr,
  output logic [SW-1:0] bif_size,
  output logic          bif_write,
  output owner_e        owner,
  output logic          beat,
  output logic          done,
  output logic          idle
);

  localparam int NW = SW + 2;

  seq_state_e    state_q, state_d;
  owner_e        owner_q, owner_d;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q;
  logic          wr_q;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] total_q;
  logic [NW-1:0] span;
  logic          done_q;
  logic          start, last;
  logic          ld_en, cnt_en;

  assign span   = (NW'(sel_addr[1:0]) + NW'(sel_size) + NW'(3)) >> 2;
  assign start  = (state_q == ST_IDLE) && (pick != OWN_NONE);
  assign beat   = (state_q != ST_IDLE) && bif_active && bif_dready &&
                  (cnt_q < total_q);
  assign last   = beat && ((cnt_q + NW'(1)) == total_q);
  assign ld_en  = start;
  assign cnt_en = start || beat;

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_REQ;
        owner_d = pick;
      end
      ST_REQ:  if (bif_active) state_d = ST_XFER;
      ST_XFER: if (!bif_active) begin
        state_d = ST_IDLE;
        owner_d = OWN_NONE;
      end
      default: begin
        state_d = ST_IDLE;
        owner_d = OWN_NONE;
      end
    endcase
    if (start)     cnt_d = '0;
    else if (beat) cnt_d = cnt_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= OWN_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      done_q  <= last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      total_q <= '0;
    end else if (ld_en) begin
      addr_q  <= sel_addr;
      size_q  <= sel_size;
      wr_q    <= sel_write;
      total_q <= span;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bif_req   = (state_q != ST_IDLE);
  assign bif_addr  = addr_q;
  assign bif_size  = size_q;
  assign bif_write = wr_q;
  assign owner     = owner_q;
  assign done      = done_q;
  assign idle      = (state_q == ST_IDLE);

endmodule

// File: rtl/dma_busmaster_ctl.sv
module dma_busmaster_ctl
  import bm_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_req,
  input  logic [AW-1:0] lp_addr,
  input  logic [SW-1:0] lp_size,
  input  logic          lp_write,
  input  logic [DW-1:0] lp_wdata,
  input  logic          lp_yield,
  output logic          lp_own,
  output logic          lp_wnext,
  output logic          lp_rvalid,
  output logic          lp_done,
  input  logic          de_req,
  input  logic [AW-1:0] de_addr,
  input  logic [SW-1:0] de_size,
  input  logic          de_write,
  input  logic [DW-1:0] de_wdata,
  output logic          de_own,
  output logic          de_wnext,
  output logic          de_rvalid,
  output logic          de_done,
  output logic [DW-1:0] rd_data,
  output logic          bif_req,
  output logic [AW-1:0] bif_addr,
  output logic [SW-1:0] bif_size,
  output logic          bif_write,
  output logic [DW-1:0] bif_wdata,
  input  logic          bif_active,
  input  logic          bif_dready,
  input  logic [DW-1:0] bif_rdata
);

  logic          rst_core_n;
  logic          seq_idle, seq_beat, seq_done;
  owner_e        pick, owner;
  logic [AW-1:0] sel_addr;
  logic [SW-1:0] sel_size;
  logic          sel_write;

  bm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bm_owner_arb u_arb (
    .can_start (seq_idle && !bif_active),
    .lp_req    (lp_req),
    .de_req    (de_req),
    .lp_yield  (lp_yield),
    .pick      (pick)
  );

  always_comb begin
    if (pick == OWN_DE) begin
      sel_addr  = de_addr;
      sel_size  = de_size;
      sel_write = de_write;
    end else begin
      sel_addr  = lp_addr;
      sel_size  = lp_size;
      sel_write = lp_write;
    end
  end

  bm_xfer_seq #(.AW(AW), .SW(SW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .pick       (pick),
    .sel_addr   (sel_addr),
    .sel_size   (sel_size),
    .sel_write  (sel_write),
    .bif_active (bif_active),
    .bif_dready (bif_dready),
    .bif_req    (bif_req),
    .bif_addr   (bif_addr),
    .bif_size   (bif_size),
    .bif_write  (bif_write),
    .owner      (owner),
    .beat       (seq_beat),
    .done       (seq_done),
    .idle       (seq_idle)
  );

  assign lp_own    = (owner == OWN_LP);
  assign de_own    = (owner == OWN_DE);
  assign lp_wnext  = lp_own && seq_beat && bif_write;
  assign de_wnext  = de_own && seq_beat && bif_write;
  assign lp_rvalid = lp_own && seq_beat && !bif_write;
  assign de_rvalid = de_own && seq_beat && !bif_write;
  assign lp_done   = lp_own && seq_done;
  assign de_done   = de_own && seq_done;
  assign rd_data   = bif_rdata;
  assign bif_wdata = de_own ? de_wdata : (lp_own ? lp_wdata : '0);

endmodule

// File: rtl/bm_busmaster_chk.sv
module bm_busmaster_chk #(
  parameter int AW = 32,
  parameter int SW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lp_req,
  input logic          lp_yield,
  input logic          lp_own,
  input logic          de_own,
  input logic          lp_wnext,
  input logic          de_wnext,
  input logic          lp_rvalid,
  input logic          de_rvalid,
  input logic          lp_done,
  input logic          de_done,
  input logic          bif_req,
  input logic [AW-1:0] bif_addr,
  input logic [SW-1:0] bif_size,
  input logic          bif_write,
  input logic          bif_active,
  input logic          bif_dready
);

  localparam int NW = SW + 2;

  logic [NW-1:0] exp_n;
  logic [NW-1:0] seen_q;

  assign exp_n = (NW'(bif_addr[1:0]) + NW'(bif_size) + NW'(3)) >> 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       seen_q <= '0;
    else if (!bif_req)                                seen_q <= '0;
    else if (bif_active && bif_dready && seen_q < exp_n) seen_q <= seen_q + NW'(1);
  end

  a_r2_req_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bif_req) |-> !$past(bif_active));

  a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bif_req && !bif_active && $past(bif_active)) |=> !bif_req);

  a_r3_stable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bif_req && $past(bif_req)) |->
      ($stable(bif_addr) && $stable(bif_size) && $stable(bif_write)));

  a_r4_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_done || de_done) |-> (seen_q == exp_n));

  a_r7_lp_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bif_req) && $past(lp_req)) |-> lp_own);

  a_r8_yield_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_own) |-> $past(lp_yield));

  a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_own, de_own}));

  a_r9_lp_strobe_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wnext || lp_rvalid || lp_done) |-> lp_own);

  a_r9_de_strobe_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (de_wnext || de_rvalid || de_done) |-> de_own);

  a_r10_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bif_active |-> !(lp_wnext || de_wnext || lp_rvalid || de_rvalid));

endmodule

bind dma_busmaster_ctl bm_busmaster_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lp_req     (lp_req),
  .lp_yield   (lp_yield),
  .lp_own     (lp_own),
  .de_own     (de_own),
  .lp_wnext   (lp_wnext),
  .de_wnext   (de_wnext),
  .lp_rvalid  (lp_rvalid),
  .de_rvalid  (de_rvalid),
  .lp_done    (lp_done),
  .de_done    (de_done),
  .bif_req    (bif_req),
  .bif_addr   (bif_addr),
  .bif_size   (bif_size),
  .bif_write  (bif_write),
  .bif_active (bif_active),
  .bif_dready (bif_dready)
);

// File: tb/dma_busmaster_ctl_tb.sv
`timescale 1ns/1ps
module dma_busmaster_ctl_tb_top;

  localparam int AW = 32;
  localparam int SW = 12;
  localparam int DW = 32;
  localparam logic [31:0] WB = 32'hA500_0000;
  localparam logic [31:0] RB = 32'h5A00_0000;

  typedef struct packed {
    logic        de;
    logic        wr;
    logic        yld;
    logic        extra;
    logic [31:0] addr;
    logic [11:0] size;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 12'd16},
    '{1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0203, 12'd2},
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0401, 12'd7},
    '{1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0802, 12'd1},
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_03FC, 12'd4},
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0010, 12'd9}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lp_req, lp_write, lp_yield;
  logic [AW-1:0] lp_addr;
  logic [SW-1:0] lp_size;
  logic [DW-1:0] lp_wdata;
  logic          lp_own, lp_wnext, lp_rvalid, lp_done;
  logic          de_req, de_write;
  logic [AW-1:0] de_addr;
  logic [SW-1:0] de_size;
  logic [DW-1:0] de_wdata;
  logic          de_own, de_wnext, de_rvalid, de_done;
  logic [DW-1:0] rd_data;
  logic          bif_req, bif_write, bif_active, bif_dready;
  logic [AW-1:0] bif_addr;
  logic [SW-1:0] bif_size;
  logic [DW-1:0] bif_wdata, bif_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_busmaster_ctl #(.AW(AW), .SW(SW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lp_req(lp_req), .lp_addr(lp_addr), .lp_size(lp_size), .lp_write(lp_write),
    .lp_wdata(lp_wdata), .lp_yield(lp_yield), .lp_own(lp_own), .lp_wnext(lp_wnext),
    .lp_rvalid(lp_rvalid), .lp_done(lp_done),
    .de_req(de_req), .de_addr(de_addr), .de_size(de_size), .de_write(de_write),
    .de_wdata(de_wdata), .de_own(de_own), .de_wnext(de_wnext),
    .de_rvalid(de_rvalid), .de_done(de_done),
    .rd_data(rd_data),
    .bif_req(bif_req), .bif_addr(bif_addr), .bif_size(bif_size),
    .bif_write(bif_write), .bif_wdata(bif_wdata), .bif_active(bif_active),
    .bif_dready(bif_dready), .bif_rdata(bif_rdata)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic any_strobe();
    return lp_wnext | lp_rvalid | de_wnext | de_rvalid;
  endfunction

  task automatic run_xfer(input logic de, input logic wr, input logic yld,
                          input logic extra, input logic [31:0] addr,
                          input logic [11:0] size);
    int n;
    n = (int'(addr[1:0]) + int'(size) + 3) / 4;
    lp_yield = yld;
    if (de) begin
      de_addr = addr; de_size = size; de_write = wr; de_req = 1'b1;
    end else begin
      lp_addr = addr; lp_size = size; lp_write = wr; lp_req = 1'b1;
    end
    @(negedge clk);
    chk("R2 request raised", 64'(bif_req), 64'd1);
    chk("R7/R8 owner granted", 64'(de ? de_own : lp_own), 64'd1);
    chk("R9 other not owner", 64'(de ? lp_own : de_own), 64'd0);
    chk("R3 address", 64'(bif_addr), 64'(addr));
    chk("R3 size", 64'(bif_size), 64'(size));
    chk("R3 direction", 64'(bif_write), 64'(wr));
    if (extra) begin
      bif_dready = 1'b1;
      #1 chk("R10 dready without active", 64'(any_strobe()), 64'd0);
      @(negedge clk);
      bif_dready = 1'b0;
    end
    bif_active = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % 2 == 1) begin
        bif_dready = 1'b0;
        #1 chk("R5/R6 no strobe in gap", 64'(any_strobe()), 64'd0);
        @(negedge clk);
      end
      bif_dready = 1'b1;
      bif_rdata  = RB + 32'(i);
      if (de) de_wdata = WB + 32'(i); else lp_wdata = WB + 32'(i);
      #1;
      chk("R3 address held", 64'(bif_addr), 64'(addr));
      if (wr) begin
        chk("R5 wnext", 64'(de ? de_wnext : lp_wnext), 64'd1);
        chk("R5 write data", 64'(bif_wdata), 64'(WB + 32'(i)));
      end else begin
        chk("R6 rvalid", 64'(de ? de_rvalid : lp_rvalid), 64'd1);
        chk("R6 read data", 64'(rd_data), 64'(RB + 32'(i)));
      end
      chk("R9 no strobe to other",
          64'(de ? (lp_wnext | lp_rvalid) : (de_wnext | de_rvalid)), 64'd0);
      chk("R4 no early done", 64'(lp_done | de_done), 64'd0);
    end
    @(negedge clk);
    if (de) de_req = 1'b0; else lp_req = 1'b0;
    chk("R4 done pulse", 64'(de ? de_done : lp_done), 64'd1);
    chk("R9 no done to other", 64'(de ? lp_done : de_done), 64'd0);
    if (extra) begin
      bif_dready = 1'b1;
      #1 chk("R4 dready past count", 64'(any_strobe()), 64'd0);
      @(negedge clk);
      chk("R4 done one clock", 64'(lp_done | de_done), 64'd0);
      chk("R2 request held while active", 64'(bif_req), 64'd1);
    end
    bif_dready = 1'b0;
    bif_active = 1'b0;
    @(negedge clk);
    chk("R2 request dropped", 64'(bif_req), 64'd0);
    chk("R4 done cleared", 64'(lp_done | de_done), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    lp_req = 0; lp_write = 0; lp_yield = 0; lp_addr = '0; lp_size = '0; lp_wdata = '0;
    de_req = 0; de_write = 0; de_addr = '0; de_size = '0; de_wdata = '0;
    bif_active = 0; bif_dready = 0; bif_rdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 req in reset", 64'(bif_req), 64'd0);
    chk("R1 owners in reset", 64'({lp_own, de_own}), 64'd0);
    chk("R1 done in reset", 64'({lp_done, de_done}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", 64'({bif_req, lp_own, de_own}), 64'd0);

    for (int v = 0; v < 6; v++)
      run_xfer(VECS[v].de, VECS[v].wr, VECS[v].yld, VECS[v].extra,
               VECS[v].addr, VECS[v].size);

    // R7: both pending, list processor must win, data engine follows
    de_addr = 32'h0000_0020; de_size = 12'd4; de_write = 1'b0; de_req = 1'b1;
    run_xfer(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0040, 12'd8);
    run_xfer(1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0020, 12'd4);

    // R8: data engine ignored without yield
    lp_yield = 1'b0;
    de_addr = 32'h0000_0600; de_size = 12'd12; de_write = 1'b1; de_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no request without yield", 64'(bif_req), 64'd0);
    chk("R8 no data engine owner", 64'(de_own), 64'd0);
    run_xfer(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0600, 12'd12);

    // R2: no request while active is high outside a cycle
    lp_yield = 1'b0;
    lp_addr = 32'h0000_0700; lp_size = 12'd5; lp_write = 1'b0; lp_req = 1'b1;
    bif_active = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 no request under active", 64'(bif_req), 64'd0);
    chk("R2 no owner under active", 64'(lp_own), 64'd0);
    bif_active = 1'b0;
    run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0700, 12'd5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule